// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block guards a small microcontroller against runaway software. It sits on a simple byte-wide register bus with two addresses: a write-only key port and a control/status register. Software starts the watchdog, and later refreshes it, by writing a fixed two-byte key pair to the key port. A second key pair asks for an immediate software reset. Any byte that breaks either pair is treated as a fault and forces a reset.

Once started, a free-running counter measures the timeout period that the control register selects. If no refresh arrives before the period ends, the block raises a reset request for a fixed number of cycles. It can also drive the chip's reset pin to a configured level. Two sticky cause flags record why the last reset happened. They survive the reset, and software clears them. An idle input, together with a control bit, can freeze the count while the core sleeps.

Top module: `keyed_wdt`

## Requirements
- R1: Writing 0x1E and then 0xE1 to the key address (reg_addr_i = 1) starts a stopped watchdog from count zero. After that, bit 5 of the control register (enable status) reads 1.
- R2: Without a valid refresh, rst_req_o rises exactly P clock cycles after the edge that accepted the arming pair. Writing the pair again while the watchdog runs restarts the count from zero. On expiry, control bit 7 (overflow flag) is set.
- R3: Writing 0x5A and then 0xA5 to the key address raises rst_req_o at the edge that accepts the second byte and sets control bit 6 (software-reset flag).
- R4: A key write that breaks a sequence raises rst_req_o at once and sets both bits 7 and 6. This covers a first byte other than 0x1E or 0x5A, a second byte other than 0xE1 after 0x1E, and a second byte other than 0xA5 after 0x5A.
- R5: Only the hardware sets bits 7 and 6. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. Both bits keep their value through a generated reset.
- R6: Bit 5 is read-only. During and after any generated reset the watchdog is stopped and the key sequence checker is back at its start, so the block needs a fresh arming pair.
- R7: While idle_i is high, the count holds when control bit 4 (idle halt) is 1 and keeps running when it is 0.
- R8: rst_req_o stays high for exactly RST_CYCLES consecutive cycles per generated reset.
- R9: While rst_req_o is high and control bit 3 (pin-drive disable) is 0, rst_pin_oe_o is 1 and rst_pin_o equals PIN_POL. When bit 3 is 1, rst_pin_oe_o stays 0. rst_pin_o is the inverse of PIN_POL whenever rst_pin_oe_o is 0.
- R10: Control bits 2..0 (N) select the period P = 2^(BASE_LOG2+N) cycles, which is 16K cycles at N=0 and 2048K at N=7 with the default BASE_LOG2=14. Reading the key address returns 0.
- R11: Bus writes to either address are ignored while rst_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| reg_we_i | input | 1 | Bus write strobe |
| reg_addr_i | input | 1 | 0: control/status, 1: key port |
| reg_wdata_i | input | 8 | Bus write data |
| reg_rdata_o | output | 8 | Bus read data for reg_addr_i |
| idle_i | input | 1 | Core is in idle mode |
| rst_req_o | output | 1 | Reset request to the chip |
| rst_pin_oe_o | output | 1 | Output enable for the reset pin driver |
| rst_pin_o | output | 1 | Level for the reset pin driver |

## Verification
Assertions run on every cycle and check four groups of behaviour. The first is that each kind of cause (expiry, software key, broken key) produces a request and the matching flags on the next cycle. The second is that the watchdog is always stopped while a request is active. The third is that the flags never drop without a control write, the configuration stays put during a request, and the count holds under idle halt. The fourth is that every request lasts exactly the configured length. Only the bench scenarios can show the exact timeout period for several select values, that a refresh really pushes expiry back, and the bus-visible effects: which byte patterns count as broken, how the flags are written and cleared, and what the pin drive does.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [7:0] KEY_ARM_A = 8'h1E;
  localparam logic [7:0] KEY_ARM_B = 8'hE1;
  localparam logic [7:0] KEY_SWR_A = 8'h5A;
  localparam logic [7:0] KEY_SWR_B = 8'hA5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;

  localparam int TSEL_W  = 3;
  localparam int BIT_OVF  = 7;
  localparam int BIT_SWF  = 6;
  localparam int BIT_HALT = 4;
  localparam int BIT_DIS  = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_SWR  = 2'd2
  } seq_e;
endpackage

// File: rtl/keyed_wdt_keychk.sv
module keyed_wdt_keychk
  import keyed_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       arm_o,
  output logic       swr_o,
  output logic       bad_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    arm_o = 1'b0;
    swr_o = 1'b0;
    bad_o = 1'b0;
    if (wr_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (data_i == KEY_ARM_A)      st_d = SEQ_ARM;
          else if (data_i == KEY_SWR_A) st_d = SEQ_SWR;
          else                          bad_o = 1'b1;
        end
        SEQ_ARM: begin
          st_d = SEQ_IDLE;
          if (data_i == KEY_ARM_B) arm_o = 1'b1;
          else                     bad_o = 1'b1;
        end
        SEQ_SWR: begin
          st_d = SEQ_IDLE;
          if (data_i == KEY_SWR_B) swr_o = 1'b1;
          else                     bad_o = 1'b1;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= SEQ_IDLE;
    else if (clr_i) st_q <= SEQ_IDLE;
    else            st_q <= st_d;
  end

  // R6: checker is back at start while a reset is being generated
  a_r6_seq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> st_q == SEQ_IDLE);
endmodule

// File: rtl/keyed_wdt_cnt.sv
module keyed_wdt_cnt
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              arm_i,
  input  logic              idle_i,
  input  logic              halt_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output logic              en_o,
  output logic              expire_o
);
  localparam int CW = BASE_LOG2 + (1 << TSEL_W);

  logic [CW-1:0] cnt_q, lim_m1;
  logic          en_q, adv;

  assign lim_m1   = ({{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(tsel_i))) - {{(CW-1){1'b0}}, 1'b1};
  assign adv      = en_q && !(idle_i && halt_i);
  assign expire_o = adv && (cnt_q >= lim_m1) && !arm_i;
  assign en_o     = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i || expire_o) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (arm_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_arm_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && !clr_i |=> en_q && cnt_q == '0);

  a_r7_idle_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && idle_i && halt_i && !arm_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdt_rstgen.sv
module keyed_wdt_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (fire_i)       cnt_q <= RW'(RST_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign req_o = (cnt_q != '0);

  // checker: length of each request pulse
  logic [RW:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    len_q <= '0;
    else if (req_o) len_q <= len_q + 1'b1;
    else            len_q <= '0;
  end

  a_r8_req_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> req_o);

  a_r8_req_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> len_q == (RW+1)'(RST_CYCLES));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int RST_CYCLES = 16,
  parameter bit PIN_POL    = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       idle_i,
  output logic       rst_req_o,
  output logic       rst_pin_oe_o,
  output logic       rst_pin_o
);
  logic              key_we, ctl_we;
  logic              arm, swr, bad, expire, fire, clr, en;
  logic              ovf_q, swf_q, halt_q, dis_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [7:0]        ctl_rd;

  assign key_we = reg_we_i && (reg_addr_i == ADDR_KEY)  && !rst_req_o;
  assign ctl_we = reg_we_i && (reg_addr_i == ADDR_CTRL) && !rst_req_o;

  // sequence faults and software resets stop the counter in the same edge
  assign clr  = rst_req_o || swr || bad;
  assign fire = expire || swr || bad;

  keyed_wdt_keychk u_keychk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_req_o || fire),
    .wr_i   (key_we),
    .data_i (reg_wdata_i),
    .arm_o  (arm),
    .swr_o  (swr),
    .bad_o  (bad)
  );

  keyed_wdt_cnt #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .arm_i    (arm),
    .idle_i   (idle_i),
    .halt_i   (halt_q),
    .tsel_i   (tsel_q),
    .en_o     (en),
    .expire_o (expire)
  );

  keyed_wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .req_o  (rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      swf_q  <= 1'b0;
      halt_q <= 1'b0;
      dis_q  <= 1'b0;
      tsel_q <= '0;
    end else begin
      if (ctl_we) begin
        ovf_q  <= ovf_q & reg_wdata_i[BIT_OVF];
        swf_q  <= swf_q & reg_wdata_i[BIT_SWF];
        halt_q <= reg_wdata_i[BIT_HALT];
        dis_q  <= reg_wdata_i[BIT_DIS];
        tsel_q <= reg_wdata_i[TSEL_W-1:0];
      end
      // hardware set wins over a clearing write
      if (expire || bad) ovf_q <= 1'b1;
      if (swr || bad)    swf_q <= 1'b1;
    end
  end

  assign ctl_rd       = {ovf_q, swf_q, en, halt_q, dis_q, tsel_q};
  assign reg_rdata_o  = (reg_addr_i == ADDR_CTRL) ? ctl_rd : 8'h00;
  assign rst_pin_oe_o = rst_req_o && !dis_q;
  assign rst_pin_o    = rst_pin_oe_o ? PIN_POL : !PIN_POL;

  a_r2_expire_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> rst_req_o && ovf_q);

  a_r3_swr_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> rst_req_o && swf_q);

  a_r4_bad_sets_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> rst_req_o && ovf_q && swf_q);

  a_r5_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we |=> !$fell(ovf_q) && !$fell(swf_q));

  a_r6_stopped_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !en);

  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> $stable({halt_q, dis_q, tsel_q}));
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int BL2 = 4;
  localparam int RC  = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       idle_i = 1'b0;
  logic       rst_req_o, rst_pin_oe_o, rst_pin_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  keyed_wdt #(.BASE_LOG2(BL2), .RST_CYCLES(RC), .PIN_POL(1'b0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .idle_i(idle_i),
    .rst_req_o(rst_req_o), .rst_pin_oe_o(rst_pin_oe_o), .rst_pin_o(rst_pin_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic arm();
    wr(1'b1, 8'h1E);
    wr(1'b1, 8'hE1);
  endtask

  task automatic wait_done();
    while (rst_req_o) @(negedge clk_i);
  endtask

  // expects rst_req_o low for n-1 more edges and high at edge n
  task automatic wait_expire(input string req, input int n);
    repeat (n - 1) @(negedge clk_i);
    chk({req, " no early expiry"}, rst_req_o, 1'b0);
    @(negedge clk_i);
    chk({req, " expiry"}, rst_req_o, 1'b1);
    wait_done();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d);
    chk("R6 reset ctrl", d, 8'h00);
    chk("R8 reset req", rst_req_o, 1'b0);
    chk("R9 reset oe", rst_pin_oe_o, 1'b0);
    chk("R9 reset pin", rst_pin_o, 1'b1);
    rd(1'b1, d);
    chk("R10 key reads zero", d, 8'h00);
  endtask

  task automatic t_arm();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    arm();
    rd(1'b0, d);
    chk("R1 enable status", d, 8'h20);
    wait_expire("R2", 15);
    rd(1'b0, d);
    chk("R2 ovf set R6 stopped", d, 8'h80);
  endtask

  task automatic t_refresh();
    wr(1'b0, 8'h00);
    arm();
    repeat (10) @(negedge clk_i);
    chk("R2 still running", rst_req_o, 1'b0);
    arm();
    wait_expire("R2 refresh", 16);
  endtask

  task automatic t_tsel();
    logic [7:0] d;
    wr(1'b0, 8'h01);
    arm();
    wait_expire("R10 sel1", 32);
    wr(1'b0, 8'h03);
    arm();
    wait_expire("R10 sel3", 128);
    rd(1'b0, d);
    chk("R10 sel kept", d, 8'h83);
  endtask

  task automatic t_idle();
    wr(1'b0, 8'h10);
    arm();
    idle_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R7 frozen no expiry", rst_req_o, 1'b0);
    idle_i = 1'b0;
    wait_expire("R7 halted", 16);
    wr(1'b0, 8'h00);
    arm();
    idle_i = 1'b1;
    wait_expire("R7 not halted", 16);
    idle_i = 1'b0;
  endtask

  task automatic t_swr();
    logic [7:0] d;
    int n;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h5A);
    chk("R3 first byte no reset", rst_req_o, 1'b0);
    wr(1'b1, 8'hA5);
    chk("R3 immediate req", rst_req_o, 1'b1);
    chk("R9 oe on", rst_pin_oe_o, 1'b1);
    chk("R9 pin polarity", rst_pin_o, 1'b0);
    n = 1;
    @(negedge clk_i);
    while (rst_req_o) begin
      n++;
      @(negedge clk_i);
    end
    chk("R8 req length", n, RC);
    rd(1'b0, d);
    chk("R3 R5 swf kept after reset", d, 8'h40);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h33);
    chk("R4 bad first byte req", rst_req_o, 1'b1);
    wait_done();
    rd(1'b0, d);
    chk("R4 bad first flags", d, 8'hC0);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h1E);
    wr(1'b1, 8'hA5);
    chk("R4 bad after arm key req", rst_req_o, 1'b1);
    wait_done();
    rd(1'b0, d);
    chk("R4 bad after arm key flags", d, 8'hC0);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h5A);
    wr(1'b1, 8'hE1);
    chk("R4 bad after swr key req", rst_req_o, 1'b1);
    wait_done();
    wr(1'b0, 8'h00);
    arm();
    wr(1'b1, 8'h00);
    chk("R4 bad while running", rst_req_o, 1'b1);
    wait_done();
    rd(1'b0, d);
    chk("R4 R6 flags and stopped", d, 8'hC0);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    wr(1'b0, 8'hE0);
    rd(1'b0, d);
    chk("R5 R6 ones do not set", d, 8'h00);
    wr(1'b1, 8'h5A);
    wr(1'b1, 8'hA5);
    wait_done();
    wr(1'b0, 8'hC0);
    rd(1'b0, d);
    chk("R5 write one keeps", d, 8'h40);
    wr(1'b0, 8'h80);
    rd(1'b0, d);
    chk("R5 write zero clears", d, 8'h00);
  endtask

  task automatic t_dis();
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h77);
    chk("R9 req with disable", rst_req_o, 1'b1);
    chk("R9 oe off", rst_pin_oe_o, 1'b0);
    chk("R9 pin idle level", rst_pin_o, 1'b1);
    wait_done();
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h5A);
    wr(1'b1, 8'hA5);
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h1E);
    wait_done();
    rd(1'b0, d);
    chk("R11 ctrl write ignored", d, 8'h40);
    wr(1'b1, 8'hE1);
    chk("R11 R6 key ignored so E1 is bad", rst_req_o, 1'b1);
    wait_done();
    rd(1'b0, d);
    chk("R11 flags after bad", d, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    fork
      begin
        t_reset();
        t_arm();
        t_refresh();
        t_tsel();
        t_idle();
        t_swr();
        t_bad();
        t_flags();
        t_dis();
        t_gate();
      end
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule